// File: doc/BRIEF.md
# Bi-Endian Load/Store Lane Aligner

This block sits between a data path built from 64-bit registers and a memory that is always accessed one whole, aligned 64-bit double word at a time. For a load, the memory returns the full double word that holds the requested item. The block moves the item of 1, 2, 4 or 8 bytes down into the least significant bits of the register result. It fills the bits above the item with copies of the item's sign bit or with zeros, as a per-request control bit selects. For a store, it moves the register's low bytes to the byte lanes the item occupies in memory and raises one write enable per written lane. The memory can then update single bytes without a read-modify-write.

The byte order is chosen on every request by a mode input. In little-endian mode, the byte at offset 0 of the double word lies in the least significant lane. In big-endian mode it lies in the most significant lane. A request whose byte offset is not a multiple of its size is refused: the block raises a fault and produces no load result and no write enables. Every result is registered and appears exactly one clock after the request.

Top module: `ldst_aligner`

## Requirements
- R1: While rst_n is low at a rising clock edge, every output (ld_valid, ld_data, st_valid, st_wdata, st_be, align_fault) is driven to zero, regardless of the request inputs.
- R2: req_size encodes the item size as 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. A request whose req_offset is not a multiple of that size raises align_fault for one cycle, and in that cycle ld_valid, st_valid and all bits of st_be are zero.
- R3: An aligned load with big_endian low yields, one cycle later, ld_valid high with ld_data byte k (bits 8k+7..8k) equal to memory lane offset+k for every k below the size. Lane n is mem_rdata bits 8n+7..8n.
- R4: An aligned load with big_endian high yields ld_data byte k equal to memory lane 8-offset-size+k. The byte at the lowest offset becomes the most significant byte of the item.
- R5: For loads of 1, 2 or 4 bytes, the ld_data bits above the item are all copies of the item's top bit when req_signed is high, and all zero when it is low. An 8-byte load ignores req_signed.
- R6: An aligned store with big_endian low yields, one cycle later, st_valid high and st_wdata lane offset+k equal to st_data byte k for every k below the size.
- R7: An aligned store with big_endian high places st_data byte k into st_wdata lane 8-offset-size+k.
- R8: With st_valid high, st_be bit n is 1 exactly for the lanes written by R6 or R7. These are size contiguous ones, and every other st_wdata lane is zero. With st_valid low, st_be is zero.
- R9: A cycle with req_valid low produces no ld_valid, st_valid or align_fault on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_offset | input | 3 | Byte offset inside the double word |
| req_signed | input | 1 | Sign-extend narrow loads when high |
| big_endian | input | 1 | Byte-order mode for this request |
| mem_rdata | input | 64 | Whole double word read from memory |
| st_data | input | 64 | Register value to store (low bytes used) |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Right-justified, extended load result |
| st_valid | output | 1 | Store data and enables valid |
| st_wdata | output | 64 | Store data placed in memory lanes |
| st_be | output | 8 | Per-lane write enables |
| align_fault | output | 1 | Misaligned request refused |

## Verification
On every cycle the assertions check the properties that hold for any data value. At most one of load result, store result and fault is raised. A fault occurs only after a valid request whose offset is not a multiple of its size. Write enables form a single run of 1, 2, 4 or 8 ones and are clear when no store is issued. Unsigned byte loads leave the upper bits clear, and an idle cycle is followed by silence. Only the bench's scenarios show that the bytes land in the right lanes for both byte orders and every legal offset and size. They also show that sign filling copies the right bit and that reset overrides a pending request.

// File: rtl/ldst_pkg.sv
// Shared constants and types for the load/store lane aligner.
// Assumes a memory word made of a power-of-two number of byte lanes.
package ldst_pkg;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = WORD_W / LANE_W;
    localparam int unsigned OFS_W  = $clog2(LANES);
    localparam int unsigned SZ_W   = $clog2(OFS_W + 1);
    localparam int unsigned SH_W   = OFS_W + 1;

    // Size codes: the item covers 2**code byte lanes.
    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_code_t;
endpackage

// File: rtl/ldst_lane_plan.sv
// Lane planner: from size, offset and byte order, works out the byte count,
// the shift in lanes between the item's lowest-significance byte and lane 0,
// the lanes the item occupies, and whether the request is misaligned.
// Assumes offset + size never exceeds the word when the request is aligned.
module ldst_lane_plan #(
    parameter int unsigned LANES = 8,
    parameter int unsigned OFS_W = $clog2(LANES),
    parameter int unsigned SZ_W  = $clog2(OFS_W + 1),
    parameter int unsigned SH_W  = OFS_W + 1
) (
    input  logic [SZ_W-1:0]  size,
    input  logic [OFS_W-1:0] offset,
    input  logic             big_endian,
    output logic [SH_W-1:0]  nbytes,
    output logic [SH_W-1:0]  shift,
    output logic [LANES-1:0] lane_mask,
    output logic             misaligned
);
    // Byte count, alignment test and lane shift for the chosen order.
    always_comb begin
        nbytes     = SH_W'(1) << size;
        misaligned = (SH_W'(offset) & (nbytes - SH_W'(1))) != '0;
        if (big_endian)
            shift = SH_W'(LANES) - SH_W'(offset) - nbytes;
        else
            shift = SH_W'(offset);
    end

    // One occupancy bit per lane: inside [shift, shift + nbytes).
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        always_comb lane_mask[i] = (SH_W'(i) >= shift) && (SH_W'(i) < shift + nbytes);
    end
endmodule

// File: rtl/ldst_load_extract.sv
// Load extractor: shifts the fetched word down by the planned number of lanes
// and fills lanes above the item with the sign bit or zeros.
// Assumes nbytes is a power of two no larger than LANES.
module ldst_load_extract #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = WORD_W / LANE_W,
    parameter int unsigned SH_W   = $clog2(LANES) + 1
) (
    input  logic [WORD_W-1:0] rdata,
    input  logic [SH_W-1:0]   shift,
    input  logic [SH_W-1:0]   nbytes,
    input  logic              sign_ext,
    output logic [WORD_W-1:0] value
);
    logic [WORD_W-1:0] shifted;
    logic              fill;

    // Right-justify the item and pick the fill bit.
    always_comb begin
        shifted = rdata >> (int'(shift) * LANE_W);
        fill    = sign_ext && shifted[int'(nbytes) * LANE_W - 1];
    end

    // Keep lanes inside the item; replace the rest with the fill bit.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        always_comb value[j*LANE_W +: LANE_W] = (SH_W'(j) < nbytes)
            ? shifted[j*LANE_W +: LANE_W] : {LANE_W{fill}};
    end
endmodule

// File: rtl/ldst_store_place.sv
// Store placer: moves the register's low bytes up to the planned lanes and
// clears every lane the item does not occupy.
// Assumes lane_mask matches the shift and size from the planner.
module ldst_store_place #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = WORD_W / LANE_W,
    parameter int unsigned SH_W   = $clog2(LANES) + 1
) (
    input  logic [WORD_W-1:0] sdata,
    input  logic [SH_W-1:0]   shift,
    input  logic [LANES-1:0]  lane_mask,
    output logic [WORD_W-1:0] wdata
);
    logic [WORD_W-1:0] moved;

    // Shift the register bytes into memory lane position.
    always_comb moved = sdata << (int'(shift) * LANE_W);

    // Gate each lane with its enable.
    for (genvar n = 0; n < LANES; n++) begin : g_gate
        always_comb wdata[n*LANE_W +: LANE_W] = moved[n*LANE_W +: LANE_W] & {LANE_W{lane_mask[n]}};
    end
endmodule

// File: rtl/ldst_aligner.sv
// Top of the load/store lane aligner. Plans lanes for each request, extracts
// load results or places store data, refuses misaligned requests, and
// registers all results so they appear one clock after the request.
// Assumes mem_rdata holds the aligned double word for the request's cycle.
module ldst_aligner
    import ldst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              req_signed,
    input  logic              big_endian,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] st_data,
    output logic              ld_valid,
    output logic [WORD_W-1:0] ld_data,
    output logic              st_valid,
    output logic [WORD_W-1:0] st_wdata,
    output logic [LANES-1:0]  st_be,
    output logic              align_fault
);
    logic [SH_W-1:0]   nbytes;
    logic [SH_W-1:0]   shift;
    logic [LANES-1:0]  lane_mask;
    logic              misaligned;
    logic [WORD_W-1:0] ld_next;
    logic [WORD_W-1:0] st_next;
    logic              do_load;
    logic              do_store;

    ldst_lane_plan #(
        .LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W), .SH_W(SH_W)
    ) u_plan (
        .size(req_size), .offset(req_offset), .big_endian(big_endian),
        .nbytes(nbytes), .shift(shift), .lane_mask(lane_mask),
        .misaligned(misaligned)
    );

    ldst_load_extract #(
        .WORD_W(WORD_W), .LANE_W(LANE_W), .LANES(LANES), .SH_W(SH_W)
    ) u_load (
        .rdata(mem_rdata), .shift(shift), .nbytes(nbytes),
        .sign_ext(req_signed), .value(ld_next)
    );

    ldst_store_place #(
        .WORD_W(WORD_W), .LANE_W(LANE_W), .LANES(LANES), .SH_W(SH_W)
    ) u_store (
        .sdata(st_data), .shift(shift), .lane_mask(lane_mask), .wdata(st_next)
    );

    // Qualify the request: only aligned ones proceed.
    always_comb begin
        do_load  = req_valid && !req_store && !misaligned;
        do_store = req_valid &&  req_store && !misaligned;
    end

    // Result registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid    <= 1'b0;
            ld_data     <= '0;
            st_valid    <= 1'b0;
            st_wdata    <= '0;
            st_be       <= '0;
            align_fault <= 1'b0;
        end else begin
            ld_valid    <= do_load;
            st_valid    <= do_store;
            align_fault <= req_valid && misaligned;
            if (do_load)
                ld_data <= ld_next;
            if (do_store) begin
                st_wdata <= st_next;
                st_be    <= lane_mask;
            end else begin
                st_be    <= '0;
            end
        end
    end
endmodule

// File: rtl/ldst_aligner_checker.sv
// Property checker for the lane aligner, attached by bind. Relates the
// request ports to the registered results one cycle later.
module ldst_aligner_checker
    import ldst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [SZ_W-1:0]   req_size,
    input logic [OFS_W-1:0]  req_offset,
    input logic              req_signed,
    input logic              ld_valid,
    input logic [WORD_W-1:0] ld_data,
    input logic              st_valid,
    input logic [LANES-1:0]  st_be,
    input logic              align_fault
);
    logic [OFS_W:0] size_bytes;
    logic           off_bad;

    // Misalignment recomputed from the request ports.
    always_comb begin
        size_bytes = (OFS_W+1)'(1) << req_size;
        off_bad    = ((OFS_W+1)'(req_offset) & (size_bytes - (OFS_W+1)'(1))) != '0;
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ld_valid, st_valid, align_fault}) <= 1); // R2

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> $past(req_valid && off_bad)); // R2

    AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_store)); // R3

    AST_BE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> ($countones(st_be) inside {1, 2, 4, 8}) &&
                     (((st_be + (st_be & (~st_be + 1'b1))) & st_be) == '0)); // R8

    AST_BE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> st_be == '0); // R8

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && $past(!req_signed && req_size == SZ_BYTE)) |-> ld_data[WORD_W-1:LANE_W] == '0); // R5

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ld_valid && !st_valid && !align_fault); // R9
endmodule

bind ldst_aligner ldst_aligner_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_offset(req_offset), .req_signed(req_signed),
    .ld_valid(ld_valid), .ld_data(ld_data), .st_valid(st_valid),
    .st_be(st_be), .align_fault(align_fault)
);

// File: tb/sim_ldst_aligner.sv
// Scoreboard bench: the driver pushes one expected item per cycle, the
// monitor pops and compares it against the registered outputs.
module sim_ldst_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = '0;
    logic [2:0]  req_offset = '0;
    logic        req_signed = 1'b0;
    logic        big_endian = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [63:0] st_data = '0;
    logic        ld_valid, st_valid, align_fault;
    logic [63:0] ld_data, st_wdata;
    logic [7:0]  st_be;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 idle, 1 load, 2 store, 3 fault
        int          tag;
        logic [63:0] data;
        logic [7:0]  be;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    ldst_aligner u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_offset(req_offset), .req_signed(req_signed),
        .big_endian(big_endian), .mem_rdata(mem_rdata), .st_data(st_data),
        .ld_valid(ld_valid), .ld_data(ld_data), .st_valid(st_valid),
        .st_wdata(st_wdata), .st_be(st_be), .align_fault(align_fault)
    );

    task automatic check(input bit ok, input int tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory lane holding significance byte j of an item (R3, R4, R6, R7).
    function automatic int lane_of(int off, int nb, int j, bit be);
        return be ? (7 - (off + nb - 1 - j)) : (off + j);
    endfunction

    // Driver: apply one request at the falling edge and push its expectation.
    task automatic issue(input bit v, input bit st, input int sz, input int off,
                         input bit sg, input bit be, input logic [63:0] rd,
                         input logic [63:0] sd);
        exp_t e;
        int nb;
        @(negedge clk);
        req_valid = v; req_store = st; req_size = 2'(sz); req_offset = 3'(off);
        req_signed = sg; big_endian = be; mem_rdata = rd; st_data = sd;
        nb = 1 << sz;
        e.data = '0; e.be = '0;
        if (!v) begin
            e.kind = 0; e.tag = 9;                 // R9 idle
        end else if (off % nb != 0) begin
            e.kind = 3; e.tag = 2;                 // R2 fault
        end else if (!st) begin
            e.kind = 1; e.tag = be ? 4 : 3;        // R4 / R3
            for (int j = 0; j < nb; j++)
                e.data[8*j +: 8] = rd[8*lane_of(off, nb, j, be) +: 8];
            if (nb < 8 && sg && e.data[8*nb-1]) begin
                for (int b = 8*nb; b < 64; b++) e.data[b] = 1'b1;
                e.tag = 5;                         // R5 sign fill
            end else if (nb < 8 && !sg) begin
                e.tag = 5;                         // R5 zero fill
            end
        end else begin
            e.kind = 2; e.tag = be ? 7 : 6;        // R7 / R6
            for (int j = 0; j < nb; j++) begin
                e.data[8*lane_of(off, nb, j, be) +: 8] = sd[8*j +: 8];
                e.be[lane_of(off, nb, j, be)] = 1'b1;
            end
        end
        q.push_back(e);
    endtask

    // Monitor: sample 2 ns after each rising edge, compare with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(ld_valid == (e.kind == 1), e.kind == 0 ? 9 : e.tag, "ld_valid", 64'(ld_valid), 64'(e.kind == 1));
                check(st_valid == (e.kind == 2), e.kind == 0 ? 9 : e.tag, "st_valid", 64'(st_valid), 64'(e.kind == 2));
                check(align_fault == (e.kind == 3), 2, "align_fault", 64'(align_fault), 64'(e.kind == 3));
                if (e.kind == 1)
                    check(ld_data == e.data, e.tag, "ld_data", ld_data, e.data);
                if (e.kind == 2) begin
                    check(st_wdata == e.data, e.tag, "st_wdata", st_wdata, e.data);
                    check(st_be == e.be, 8, "st_be", 64'(st_be), 64'(e.be));  // R8
                end else begin
                    check(st_be == '0, e.kind == 3 ? 2 : 8, "st_be idle", 64'(st_be), 64'(0));
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] words[3];
        words[0] = 64'h434F_4D50_5554_4552;
        words[1] = 64'h8091_A2B3_C4D5_E6F7;
        words[2] = 64'hF0E1_D2C3_B4A5_9687;

        // R1: reset dominates a pending request.
        req_valid = 1'b1; req_store = 1'b1; st_data = '1; mem_rdata = '1;
        repeat (3) @(posedge clk);
        #2;
        check(!ld_valid && !st_valid && !align_fault, 1, "reset flags",
              {61'd0, ld_valid, st_valid, align_fault}, 64'd0);
        check(ld_data == '0 && st_wdata == '0 && st_be == '0, 1, "reset data",
              ld_data | st_wdata | 64'(st_be), 64'd0);
        @(negedge clk);
        rst_n = 1'b1; req_valid = 1'b0;

        issue(0, 0, 0, 0, 0, 0, '0, '0);
        // Full sweep: order, size, offset, direction, signedness.
        for (int be = 0; be < 2; be++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 8; off++)
                    for (int st = 0; st < 2; st++)
                        for (int sg = 0; sg < 2; sg++) begin
                            issue(1, st[0], sz, off, sg[0], be[0],
                                  words[(sz + off + sg) % 3], words[(off + 1) % 3]);
                            if (((off + sz) % 5) == 0)
                                issue(0, st[0], sz, off, sg[0], be[0], '1, '1);
                        end
        // Order changes on back-to-back requests.
        issue(1, 0, 0, 4, 0, 1, words[0], '0);
        issue(1, 0, 0, 4, 0, 0, words[0], '0);
        issue(1, 1, 1, 2, 0, 1, '0, 64'h0000_0000_0000_ABCD);
        issue(1, 1, 1, 2, 0, 0, '0, 64'h0000_0000_0000_ABCD);
        issue(0, 0, 0, 0, 0, 0, '0, '0);
        issue(0, 0, 0, 0, 0, 0, '0, '0);
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule